// File: doc/BRIEF.md
# Big-Endian Aligned Load-Store Unit

This unit sits between a 32-bit integer core and a byte-addressed data store with a 16-bit physical address space. The core hands it one request per cycle. Each request is a load or a store of a byte, a half-word or a word, and loads may use signed or unsigned extension. The unit turns each request into a single word-wide access with a per-lane write mask. Byte lanes are placed big-endian, so the most significant byte of a multi-byte value lands at the lowest address. Load data is shifted down and extended before it is returned.

Any request whose address does not suit its size is refused. The unit flags it with an error on the response, and the store behind it is never written. The data store is a single-cycle synchronous RAM built from one 8-bit column per byte lane. Its depth is a parameter, and address bits above that depth are ignored, so addresses alias. Every accepted request gets exactly one response on the following cycle.

Top module: `bigend_lsu`

## Requirements
- R1: While reset is held and on the first cycle after it, rsp_valid, rsp_err and rsp_rdata are all 0.
- R2: rsp_valid is 1 on the cycle after every cycle with req_valid=1, and 0 on the cycle after every cycle with req_valid=0.
- R3: The size codes are 00 byte, 01 half-word, 10 word and 11 reserved. A half-word with req_addr[0]=1, a word with req_addr[1:0]!=00, or any request with code 11 gets rsp_err=1 and rsp_rdata=0. Such a request writes no byte of memory.
- R4: After a word store of 0xAABBCCDD to address 0, an unsigned byte load of address 0 returns 0x000000AA and one of address 3 returns 0x000000DD.
- R5: A byte store writes only the addressed byte and takes it from req_wdata[7:0]. Data bits 31:24 of a word hold offset 0 and bits 7:0 hold offset 3.
- R6: A half-word store writes only the two addressed bytes. req_wdata[15:8] goes to the lower address and req_wdata[7:0] to the higher one.
- R7: With req_uns=0, a byte load fills bits 31:8 with bit 7 of the byte, and a half-word load fills bits 31:16 with bit 15.
- R8: With req_uns=1, a byte load returns zeros in bits 31:8 and a half-word load returns zeros in bits 31:16.
- R9: A word load returns the whole word at the aligned address, bit 31 first.
- R10: The response to an aligned store has rsp_err=0 and rsp_rdata=0.
- R11: Only address bits [MEM_AW+1:0] select a byte, so addresses that differ only above bit MEM_AW+1 reach the same byte (0x0070, 0x1070 and 0xF070 with MEM_AW=10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| req_uns | input | 1 | Loads: 1 zero-extends, 0 sign-extends |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | That request was misaligned or had a reserved size |
| rsp_rdata | output | 32 | Extended load data; 0 for stores and errors |

## Verification
The bench writes known words and reads them back at every byte and half-word offset. A design with little-endian lanes would return 0xDD where 0xAA is expected, and a design with a reversed write mask would corrupt the neighbouring bytes of a narrow store. The bench makes misaligned stores next to known data and then reads that data back. A unit that masked the write too late would leave changed bytes, and one that reported the error without blocking the write would fail the read-back. Signed loads use values with the top bit set and then clear. An extension taken from the wrong bit shows up as a wrong upper half. An alias read through high address bits catches an index decoded from the wrong bits.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

endpackage

// File: rtl/lsu_req_decode.sv
module lsu_req_decode
  import lsu_pkg::*;
(
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] offset,
  output logic             bad_align,
  output logic [LANES-1:0] lane_mask
);

  // Lane 3 (bits 31:24) holds the byte at offset 0: big-endian placement.
  always_comb begin
    bad_align = 1'b0;
    lane_mask = '0;
    unique case (size)
      SZ_BYTE: lane_mask = 4'b1000 >> offset;
      SZ_HALF: begin
        bad_align = offset[0];
        lane_mask = offset[1] ? 4'b0011 : 4'b1100;
      end
      SZ_WORD: begin
        bad_align = |offset;
        lane_mask = 4'b1111;
      end
      default: bad_align = 1'b1;
    endcase
  end

endmodule

// File: rtl/lsu_wr_steer.sv
module lsu_wr_steer
  import lsu_pkg::*;
(
  input  acc_size_e         size,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] lane_data
);

  // Narrow data is copied into every lane it could occupy; the lane mask
  // decides which copy is written.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: lane_data[8*l +: 8] = wdata[7:0];
        SZ_HALF: lane_data[8*l +: 8] = wdata[8*(l % 2) +: 8];
        default: lane_data[8*l +: 8] = wdata[8*l +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_lane_ram.sv
module lsu_lane_ram
  import lsu_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic              clk,
  input  logic              en,
  input  logic [LANES-1:0]  we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  for (genvar l = 0; l < LANES; l++) begin : g_col
    logic [7:0] col [DEPTH];

    always_ff @(posedge clk) begin
      if (en) begin
        if (we[l]) col[idx] <= wdata[8*l +: 8];
        rdata[8*l +: 8] <= col[idx];
      end
    end
  end

endmodule

// File: rtl/lsu_rd_extract.sv
module lsu_rd_extract
  import lsu_pkg::*;
(
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  offset,
  input  logic              uns,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] data
);

  logic [OFF_W-1:0] lane;
  logic [7:0]       sel_b;
  logic [15:0]      sel_h;

  always_comb begin
    lane  = ~offset;
    sel_b = word[{lane, 3'b000} +: 8];
    sel_h = offset[1] ? word[15:0] : word[31:16];
    unique case (size)
      SZ_BYTE: data = {{(WORD_W-8){~uns & sel_b[7]}}, sel_b};
      SZ_HALF: data = {{(WORD_W-16){~uns & sel_h[15]}}, sel_h};
      SZ_WORD: data = word;
      default: data = '0;
    endcase
  end

endmodule

// File: rtl/bigend_lsu.sv
module bigend_lsu
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_uns,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);

  localparam int unsigned IDX_LO = OFF_W;
  localparam int unsigned IDX_HI = MEM_AW + OFF_W - 1;

  acc_size_e         size_in;
  logic [OFF_W-1:0]  off_in;
  logic              bad_align;
  logic [LANES-1:0]  lane_mask;
  logic [WORD_W-1:0] lane_wdata;
  logic              mem_en;
  logic [LANES-1:0]  mem_we;
  logic [WORD_W-1:0] mem_q;
  logic [WORD_W-1:0] ld_data;

  logic              vld_q, err_q, ld_q, uns_q;
  acc_size_e         size_q;
  logic [OFF_W-1:0]  off_q;

  logic unused_hi_addr;
  assign unused_hi_addr = ^req_addr[ADDR_W-1:IDX_HI+1];

  assign size_in = acc_size_e'(req_size);
  assign off_in  = req_addr[OFF_W-1:0];

  lsu_req_decode u_dec (
    .size      (size_in),
    .offset    (off_in),
    .bad_align (bad_align),
    .lane_mask (lane_mask)
  );

  lsu_wr_steer u_steer (
    .size      (size_in),
    .wdata     (req_wdata),
    .lane_data (lane_wdata)
  );

  // A refused request never enables the RAM, so no lane can be written.
  assign mem_en = req_valid & ~bad_align;
  assign mem_we = (mem_en & req_write) ? lane_mask : '0;

  lsu_lane_ram #(.IDX_W(MEM_AW)) u_ram (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .idx   (req_addr[IDX_HI:IDX_LO]),
    .wdata (lane_wdata),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      ld_q   <= 1'b0;
      uns_q  <= 1'b0;
      size_q <= SZ_BYTE;
      off_q  <= '0;
    end else begin
      vld_q  <= req_valid;
      err_q  <= req_valid & bad_align;
      ld_q   <= mem_en & ~req_write;
      uns_q  <= req_uns;
      size_q <= size_in;
      off_q  <= off_in;
    end
  end

  lsu_rd_extract u_ext (
    .size   (size_q),
    .offset (off_q),
    .uns    (uns_q),
    .word   (mem_q),
    .data   (ld_data)
  );

  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = ld_q ? ld_data : '0;

endmodule

// File: rtl/lsu_sva.sv
module lsu_sva
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic              req_uns,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LANES-1:0]  mem_we,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata
);

  logic misal;
  assign misal = (req_size == 2'b11) ||
                 (req_size == 2'b01 && req_addr[0]) ||
                 (req_size == 2'b10 && req_addr[1:0] != 2'b00);

  // R3: a refused request writes no lane
  a_r3_no_write_on_err: assert property (@(posedge clk) disable iff (rst)
    (req_valid && misal) |-> (mem_we == '0));

  // R3: refused requests answer with error and zero data
  a_r3_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));

  // R2: one response per request, on the next cycle
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R5: an aligned byte store touches exactly one lane
  a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_size == 2'b00) |-> ($countones(mem_we) == 1));

  // R6: an aligned half-word store touches exactly two lanes
  a_r6_half_two_lanes: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_size == 2'b01 && !req_addr[0])
      |-> ($countones(mem_we) == 2));

  // R7: signed byte load copies bit 7 upward
  a_r7_sext_byte: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'b00 && !req_uns)
      |=> (rsp_rdata[31:8] == {24{rsp_rdata[7]}}));

  // R8: unsigned half-word load has a zero upper half
  a_r8_zext_half: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'b01 && req_uns)
      |=> (rsp_rdata[31:16] == 16'h0));

  // R10: store responses carry no data
  a_r10_store_no_data: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));

endmodule

bind bigend_lsu lsu_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_size  (req_size),
  .req_uns   (req_uns),
  .req_addr  (req_addr),
  .mem_we    (mem_we),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/sim_bigend_lsu.sv
`timescale 1ns/1ps
module sim_bigend_lsu;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_uns;
  logic [1:0]  req_size;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bigend_lsu u0 (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_uns   (req_uns),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, sample the response at the next falling edge.
  task automatic issue(input logic w, input logic [1:0] sz, input logic uns,
                       input logic [15:0] a, input logic [31:0] d,
                       output logic v, output logic e, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_uns = uns;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    v = rsp_valid; e = rsp_err; q = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic store(input string tag, input logic [1:0] sz, input logic [15:0] a,
                       input logic [31:0] d);
    logic v, e; logic [31:0] q;
    issue(1'b1, sz, 1'b0, a, d, v, e, q);
    chk({tag, " store valid"}, {31'd0, v}, 32'd1);
    chk({tag, " store err"}, {31'd0, e}, 32'd0);
    chk({tag, " store data"}, q, 32'd0);
  endtask

  task automatic load(input string tag, input logic [1:0] sz, input logic uns,
                      input logic [15:0] a, input logic [31:0] exp);
    logic v, e; logic [31:0] q;
    issue(1'b0, sz, uns, a, 32'h0, v, e, q);
    chk({tag, " load err"}, {31'd0, e}, 32'd0);
    chk(tag, q, exp);
  endtask

  task automatic refused(input string tag, input logic w, input logic [1:0] sz,
                         input logic [15:0] a);
    logic v, e; logic [31:0] q;
    issue(w, sz, 1'b0, a, 32'hFFFF_FFFF, v, e, q);
    chk({tag, " err"}, {31'd0, e}, 32'd1);
    chk({tag, " data"}, q, 32'd0);
  endtask

  task automatic t_reset_r1;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_uns = 1'b0;
    req_size = 2'b00; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 err after reset", {31'd0, rsp_err}, 32'd0);
    chk("R1 data after reset", rsp_rdata, 32'd0);
  endtask

  task automatic t_endian_r4_r9;
    store("R10 R4", 2'b10, 16'h0000, 32'hAABBCCDD);
    load("R4 byte0", 2'b00, 1'b1, 16'h0000, 32'h0000_00AA);
    load("R4 byte3", 2'b00, 1'b1, 16'h0003, 32'h0000_00DD);
    load("R4 byte1", 2'b00, 1'b1, 16'h0001, 32'h0000_00BB);
    load("R9 word", 2'b10, 1'b0, 16'h0000, 32'hAABBCCDD);
  endtask

  task automatic t_byte_r5;
    store("R5 clear", 2'b10, 16'h0050, 32'h0);
    store("R5 sb1", 2'b00, 16'h0051, 32'h1234_56A5);
    load("R5 after sb1", 2'b10, 1'b0, 16'h0050, 32'h00A5_0000);
    store("R5 sb3", 2'b00, 16'h0053, 32'hFFFF_FF3C);
    load("R5 after sb3", 2'b10, 1'b0, 16'h0050, 32'h00A5_003C);
  endtask

  task automatic t_half_r6;
    store("R6 clear", 2'b10, 16'h0060, 32'h0);
    store("R6 sh0", 2'b01, 16'h0060, 32'h9999_BEEF);
    load("R6 after sh0", 2'b10, 1'b0, 16'h0060, 32'hBEEF_0000);
    store("R6 sh2", 2'b01, 16'h0062, 32'h7777_1234);
    load("R6 after sh2", 2'b10, 1'b0, 16'h0060, 32'hBEEF_1234);
    load("R6 byte1", 2'b00, 1'b1, 16'h0061, 32'h0000_00EF);
  endtask

  task automatic t_extend_r7_r8;
    store("R7 fill", 2'b10, 16'h0040, 32'h80FF_7F01);
    load("R7 lb 0", 2'b00, 1'b0, 16'h0040, 32'hFFFF_FF80);
    load("R7 lb 2", 2'b00, 1'b0, 16'h0042, 32'h0000_007F);
    load("R7 lb 1", 2'b00, 1'b0, 16'h0041, 32'hFFFF_FFFF);
    load("R7 lh 0", 2'b01, 1'b0, 16'h0040, 32'hFFFF_80FF);
    load("R7 lh 2", 2'b01, 1'b0, 16'h0042, 32'h0000_7F01);
    load("R8 lbu 0", 2'b00, 1'b1, 16'h0040, 32'h0000_0080);
    load("R8 lbu 3", 2'b00, 1'b1, 16'h0043, 32'h0000_0001);
    load("R8 lhu 0", 2'b01, 1'b1, 16'h0040, 32'h0000_80FF);
  endtask

  task automatic t_misalign_r3;
    store("R3 fill a", 2'b10, 16'h0020, 32'h1122_3344);
    store("R3 fill b", 2'b10, 16'h0024, 32'h5566_7788);
    refused("R3 sw 0x21", 1'b1, 2'b10, 16'h0021);
    refused("R3 sw 0x22", 1'b1, 2'b10, 16'h0022);
    refused("R3 sh 0x23", 1'b1, 2'b01, 16'h0023);
    refused("R3 sh 0x25", 1'b1, 2'b01, 16'h0025);
    refused("R3 rsvd store", 1'b1, 2'b11, 16'h0024);
    refused("R3 lw 0x23", 1'b0, 2'b10, 16'h0023);
    refused("R3 lh 0x21", 1'b0, 2'b01, 16'h0021);
    refused("R3 rsvd load", 1'b0, 2'b11, 16'h0020);
    load("R3 word a kept", 2'b10, 1'b0, 16'h0020, 32'h1122_3344);
    load("R3 word b kept", 2'b10, 1'b0, 16'h0024, 32'h5566_7788);
  endtask

  task automatic t_alias_r11;
    store("R11 fill", 2'b10, 16'h0070, 32'hCAFE_F00D);
    load("R11 alias 0x1070", 2'b10, 1'b0, 16'h1070, 32'hCAFE_F00D);
    load("R11 alias 0xF070", 2'b10, 1'b0, 16'hF070, 32'hCAFE_F00D);
  endtask

  task automatic t_timing_r2;
    logic v, e; logic [31:0] q;
    @(negedge clk);
    chk("R2 idle cycle no valid", {31'd0, rsp_valid}, 32'd0);
    issue(1'b0, 2'b10, 1'b0, 16'h0000, 32'h0, v, e, q);
    chk("R2 valid after request", {31'd0, v}, 32'd1);
    @(negedge clk);
    chk("R2 valid drops", {31'd0, rsp_valid}, 32'd0);
    // back-to-back requests: one response per cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'b00; req_uns = 1'b1;
    req_addr = 16'h0000;
    @(negedge clk);
    chk("R2 b2b first", {31'd0, rsp_valid}, 32'd1);
    chk("R2 b2b first data", rsp_rdata, 32'h0000_00AA);
    req_addr = 16'h0002;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 b2b second", {31'd0, rsp_valid}, 32'd1);
    chk("R2 b2b second data", rsp_rdata, 32'h0000_00CC);
    @(negedge clk);
    chk("R2 b2b end", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    t_reset_r1();
    t_endian_r4_r9();
    t_byte_r5();
    t_half_r6();
    t_extend_r7_r8();
    t_misalign_r3();
    t_alias_r11();
    t_timing_r2();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule